// File: doc/BRIEF.md
# Configurable Serial UART with Interrupts

This block is a full-duplex asynchronous serial port. A transmit path converts a byte written into a one-entry buffer into a serial frame on `txd`. A receive path recovers frames from `rxd` into a one-entry buffer that software empties with a read strobe. Three 8-bit configuration words, written through a small address/data write port, control the port. They set the frame format, a shared bit that is either the parity sense or the transmitted ninth bit, five interrupt masks, a 12-bit baud prescaler and separate enables for each direction.

The bit clock comes from a prescaler tick that fires once every `P+1` system clocks. Each serial bit lasts 16 ticks. The receiver uses these ticks to oversample the line: it confirms a start bit half a bit after the falling edge and then samples each later bit at its centre. The receiver reports overrun, line break, stop-bit (framing) errors and parity errors. A single interrupt output combines the masked event flags and is further gated by an external global enable pin.

Top module: `sio_uart`

## Requirements
- R1: Format code 00 sends start(0), 8 data bits LSB first and one stop(1), which is 10 bits. Code 01 is the same with two stop bits, which is 11 bits. The format code is bits [1:0] of configuration word 0 (address 0).
- R2: With format code 10, a parity bit follows the 8 data bits and then one stop bit comes. Bit 2 of word 0 selects the parity sense: 0 gives odd parity (the count of ones in data plus parity is odd) and 1 gives even parity.
- R3: With format code 11, the frame carries 9 data bits and one stop bit. The transmitted ninth bit equals bit 2 of word 0.
- R4: Each bit lasts 16*(P+1) clocks. P is 12 bits wide: P[11:8] is bits [7:4] of word 1 (address 1) and P[7:0] is word 2 (address 2).
- R5: A received frame with no break is stored in `rx_data` (bits above the data width read 0) and sets `rx_full`. A pulse on `rd_en` clears `rx_full` and all receive error flags.
- R6: If a frame completes while `rx_full` is 1, `rx_ovr` is set and the new data is discarded, so `rx_data` keeps the older value.
- R7: A frame whose every sample, stop bits included, is low sets `rx_brk` and stores nothing. The receiver then waits for the line to go high before it accepts a new start bit.
- R8: A stop bit sampled low sets `rx_ferr`. In format 10, a parity mismatch against the selected sense sets `rx_perr`.
- R9: `tx_empty` goes to 1 when buffered data moves into the shifter and goes to 0 only on a data write (address 3). `tx_done` is set when the last stop bit ends with the buffer empty, and it is cleared by a data write.
- R10: `irq` = `gint_en` AND OR of the flags {rx_full, rx_ovr, rx_brk, tx_empty, tx_done}, each masked by bits [7],[6],[5],[4],[3] of word 0. When `gint_en` is 0, `irq` stays 0.
- R11: All configuration words reset to 0x00, so both directions start disabled. Bit 0 of word 1 enables transmit and bit 1 enables receive. With transmit disabled, written data waits and `txd` stays high. With receive disabled, frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0,1,2 configuration words, 3 transmit data |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Receive buffer read strobe |
| rx_data | output | 9 | Receive buffer contents |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles high |
| gint_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt |
| rx_full | output | 1 | Receive buffer holds unread data |
| rx_ovr | output | 1 | Overrun flag |
| rx_brk | output | 1 | Break flag |
| rx_ferr | output | 1 | Framing error flag |
| rx_perr | output | 1 | Parity error flag |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_done | output | 1 | Transmission finished |

## Verification
A transmitted frame starts within one clock of the load into the shifter. The monitor finds the falling start edge and samples each bit 8*(P+1) clocks after its start, at the bit centre, so the small misalignment of the first tick cannot move a sample across a bit boundary. The receive flags are registered two stages after the centre sample of the last stop bit, which is about half a bit before the frame ends. The bench therefore checks them three clocks after it stops driving the frame. Configuration and interrupt results are checked one clock after the write or pin change, and `tx_done` is checked a full bit time after the last stop-bit centre.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 9;
    localparam int FRAME_W = 12;

    typedef enum logic [1:0] {
        FMT_8N1 = 2'b00,
        FMT_8N2 = 2'b01,
        FMT_8P1 = 2'b10,
        FMT_9N1 = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_HOLD
    } rx_st_e;

    localparam logic [1:0] A_CFG0 = 2'd0;
    localparam logic [1:0] A_CFG1 = 2'd1;
    localparam logic [1:0] A_CFG2 = 2'd2;
    localparam logic [1:0] A_TXD  = 2'd3;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= presc);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
    parameter int OSR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  fmt_e              fmt,
    input  logic              pbit,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              txd,
    output logic              busy,
    output logic              buf_empty,
    output logic              done
);
    typedef struct packed {
        logic               full;
        logic [BYTE_W-1:0]  hold;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [OSR_W-1:0]   tc;
        logic               busy;
        logic               done;
    } tx_t;

    tx_t q, n;
    logic b9, last;

    always_comb begin
        n    = q;
        last = 1'b0;
        unique case (fmt)
            FMT_8P1: b9 = pbit ? ^q.hold : ~^q.hold;
            FMT_9N1: b9 = pbit;
            default: b9 = 1'b1;
        endcase
        if (q.busy) begin
            if (tick) begin
                if (q.tc == '1) begin
                    n.tc   = '0;
                    n.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                    n.left = q.left - 1'b1;
                    if (q.left == 4'd1) begin
                        n.busy = 1'b0;
                        last   = 1'b1;
                    end
                end else begin
                    n.tc = q.tc + 1'b1;
                end
            end
        end else if (en && q.full) begin
            n.busy = 1'b1;
            n.full = 1'b0;
            n.tc   = '0;
            n.sh   = {2'b11, b9, q.hold, 1'b0};
            n.left = (fmt == FMT_8N1) ? 4'd10 : 4'd11;
        end
        if (wr) begin
            n.hold = wr_data;
            n.full = 1'b1;
            n.done = 1'b0;
        end
        if (last && !n.full) n.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign txd       = q.busy ? q.sh[0] : 1'b1;
    assign busy      = q.busy;
    assign buf_empty = !q.full;
    assign done      = q.done;
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
    parameter int OSR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  fmt_e              fmt,
    input  logic              pbit,
    input  logic              rxd,
    output logic              evt,
    output logic [WORD_W-1:0] ev_data,
    output logic              ev_ferr,
    output logic              ev_perr,
    output logic              ev_brk
);
    localparam logic [OSR_W-1:0] HALF = OSR_W'((1 << (OSR_W - 1)) - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [OSR_W-1:0]  tc;
        logic [3:0]        idx;
        logic [WORD_W-1:0] sh;
        logic              ones;
        logic              ferr;
        logic [1:0]        sync;
        logic              evt;
        logic [WORD_W-1:0] ev_data;
        logic              ev_ferr;
        logic              ev_perr;
        logic              ev_brk;
    } rx_t;

    rx_t q, n;
    logic rxs;
    logic [3:0] last_data, last_stop;

    always_comb begin
        n         = q;
        n.evt     = 1'b0;
        n.sync    = {q.sync[0], rxd};
        rxs       = q.sync[1];
        last_data = (fmt == FMT_8N1 || fmt == FMT_8N2) ? 4'd7 : 4'd8;
        last_stop = (fmt == FMT_8N2) ? 4'd1 : 4'd0;
        unique case (q.st)
            RX_IDLE: if (tick && !rxs) begin
                n.st = RX_START;
                n.tc = '0;
            end
            RX_START: if (tick) begin
                if (q.tc == HALF) begin
                    if (!rxs) begin
                        n.st   = RX_BITS;
                        n.tc   = '0;
                        n.idx  = '0;
                        n.ones = 1'b0;
                        n.sh   = '0;
                    end else begin
                        n.st = RX_IDLE;
                    end
                end else begin
                    n.tc = q.tc + 1'b1;
                end
            end
            RX_BITS: if (tick) begin
                if (q.tc == '1) begin
                    n.tc   = '0;
                    n.sh   = {rxs, q.sh[WORD_W-1:1]};
                    n.ones = q.ones | rxs;
                    n.idx  = q.idx + 1'b1;
                    if (q.idx == last_data) begin
                        n.st   = RX_STOP;
                        n.idx  = '0;
                        n.ferr = 1'b0;
                    end
                end else begin
                    n.tc = q.tc + 1'b1;
                end
            end
            RX_STOP: if (tick) begin
                if (q.tc == '1) begin
                    n.tc   = '0;
                    n.ones = q.ones | rxs;
                    n.ferr = q.ferr | !rxs;
                    n.idx  = q.idx + 1'b1;
                    if (q.idx == last_stop) begin
                        n.evt     = 1'b1;
                        n.ev_brk  = !(q.ones | rxs);
                        n.ev_ferr = q.ferr | !rxs;
                        n.ev_perr = (fmt == FMT_8P1) && ((^q.sh) == pbit);
                        if (fmt == FMT_9N1)      n.ev_data = q.sh;
                        else if (fmt == FMT_8P1) n.ev_data = {1'b0, q.sh[BYTE_W-1:0]};
                        else                     n.ev_data = {1'b0, q.sh[WORD_W-1:1]};
                        n.st = n.ev_brk ? RX_HOLD : RX_IDLE;
                    end
                end else begin
                    n.tc = q.tc + 1'b1;
                end
            end
            RX_HOLD: if (rxs) n.st = RX_IDLE;
            default: n.st = RX_IDLE;
        endcase
        if (!en) begin
            n.st  = RX_IDLE;
            n.evt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= n;
        end
    end

    assign evt     = q.evt;
    assign ev_data = q.ev_data;
    assign ev_ferr = q.ev_ferr;
    assign ev_perr = q.ev_perr;
    assign ev_brk  = q.ev_brk;
endmodule

// File: rtl/sio_uart.sv
module sio_uart import sio_pkg::*; #(
    parameter int PRESC_W = 12,
    parameter int OSR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rx_data,
    input  logic              rxd,
    output logic              txd,
    input  logic              gint_en,
    output logic              irq,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              rx_brk,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              tx_empty,
    output logic              tx_done
);
    localparam int HI_W = PRESC_W - BYTE_W;

    typedef struct packed {
        logic [7:0]        cfg0;
        logic [HI_W-1:0]   presc_hi;
        logic              rx_en;
        logic              tx_en;
        logic [7:0]        presc_lo;
        logic [WORD_W-1:0] rxw;
        logic              full;
        logic              ovr;
        logic              brk;
        logic              ferr;
        logic              perr;
    } regs_t;

    regs_t q, d;
    logic tick, tx_busy, tx_wr;
    logic ev, ev_ferr, ev_perr, ev_brk;
    logic [WORD_W-1:0] ev_data;
    logic [PRESC_W-1:0] presc;
    fmt_e fmt;
    logic pbit;

    assign fmt   = fmt_e'(q.cfg0[1:0]);
    assign pbit  = q.cfg0[2];
    assign presc = {q.presc_hi, q.presc_lo};
    assign tx_wr = wr_en && (wr_addr == A_TXD);

    sio_baud #(.PRESC_W(PRESC_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .presc(presc), .tick(tick)
    );

    sio_tx #(.OSR_W(OSR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.tx_en), .fmt(fmt),
        .pbit(pbit), .wr(tx_wr), .wr_data(wr_data), .txd(txd),
        .busy(tx_busy), .buf_empty(tx_empty), .done(tx_done)
    );

    sio_rx #(.OSR_W(OSR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.rx_en), .fmt(fmt),
        .pbit(pbit), .rxd(rxd), .evt(ev), .ev_data(ev_data),
        .ev_ferr(ev_ferr), .ev_perr(ev_perr), .ev_brk(ev_brk)
    );

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CFG0: d.cfg0 = wr_data;
                A_CFG1: begin
                    d.presc_hi = wr_data[7 -: HI_W];
                    d.rx_en    = wr_data[1];
                    d.tx_en    = wr_data[0];
                end
                A_CFG2: d.presc_lo = wr_data;
                default: ;
            endcase
        end
        if (rd_en) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
            d.brk  = 1'b0;
            d.ferr = 1'b0;
            d.perr = 1'b0;
        end
        if (ev) begin
            if (ev_brk) begin
                d.brk  = 1'b1;
                d.ferr = 1'b1;
            end else if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.rxw  = ev_data;
                d.full = 1'b1;
                d.ferr = d.ferr | ev_ferr;
                d.perr = d.perr | ev_perr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.rxw;
    assign rx_full = q.full;
    assign rx_ovr  = q.ovr;
    assign rx_brk  = q.brk;
    assign rx_ferr = q.ferr;
    assign rx_perr = q.perr;
    assign irq     = gint_en &&
                     |(q.cfg0[7:3] & {q.full, q.ovr, q.brk, tx_empty, tx_done});
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gint_en,
    input logic       irq,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [8:0] rx_data,
    input logic       rx_ovr,
    input logic       rx_brk,
    input logic       rx_full,
    input logic       tx_empty,
    input logic       tx_done,
    input logic       txd,
    input logic       tx_busy
);
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gint_en |-> !irq);

    p_txe_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en && wr_addr == 2'd3));

    p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> $past(wr_en && wr_addr == 2'd3));

    p_ovr_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $stable(rx_data));

    p_brk_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_brk) |-> !$rose(rx_full));

    p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

bind sio_uart sio_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gint_en(gint_en), .irq(irq),
    .wr_en(wr_en), .wr_addr(wr_addr), .rx_data(rx_data), .rx_ovr(rx_ovr),
    .rx_brk(rx_brk), .rx_full(rx_full), .tx_empty(tx_empty),
    .tx_done(tx_done), .txd(txd), .tx_busy(tx_busy)
);

// File: tb/tb_sio_uart.sv
module tb_sio_uart;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic rd_en = 1'b0;
    logic rxd = 1'b1;
    logic gint_en = 1'b0;
    logic [8:0] rx_data;
    logic txd, irq, rx_full, rx_ovr, rx_brk, rx_ferr, rx_perr, tx_empty, tx_done;

    int total = 0;
    int bad = 0;
    int P = 0;
    int pend = 0;
    logic [1:0] fmt_cur = 2'd0;
    logic pb_cur = 1'b0;
    logic [4:0] mask_cur = 5'd0;
    logic [15:0] expq[$];
    string tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_uart dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rx_data(rx_data), .rxd(rxd),
        .txd(txd), .gint_en(gint_en), .irq(irq), .rx_full(rx_full),
        .rx_ovr(rx_ovr), .rx_brk(rx_brk), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Frame as {length, bits[11:0]}, bit 0 sent first.
    function automatic logic [15:0] frame_of(input logic [8:0] d, input logic [1:0] f, input logic pb);
        logic top;
        logic [3:0] len;
        len = (f == 2'd0) ? 4'd10 : 4'd11;
        top = 1'b1;
        if (f == 2'd2) top = pb ? ^d[7:0] : ~^d[7:0];
        if (f == 2'd3) top = d[8];
        return {len, 2'b11, top, d[7:0], 1'b0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] f, input logic pb);
        fmt_cur = f; pb_cur = pb;
        wr(2'd0, {mask_cur, pb, f});
    endtask

    task automatic tx_send(input logic [7:0] v, input string tag);
        expq.push_back(frame_of({pb_cur, v}, fmt_cur, pb_cur));
        tagq.push_back(tag);
        pend++;
        wr(2'd3, v);
    endtask

    task automatic tx_wait();
        wait (pend == 0);
        repeat (16 * (P + 1) + 4) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [15:0] fr);
        for (int i = 0; i < int'(fr[15:12]); i++) begin
            rxd = fr[i];
            repeat (16 * (P + 1)) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: decodes txd frames and compares them with the scoreboard queue.
    initial begin
        logic [11:0] got;
        logic [15:0] e;
        string t;
        int n;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                e = (expq.size() != 0) ? expq[0] : 16'hA000;
                n = int'(e[15:12]);
                got = '1;
                repeat (8 * (P + 1) - 1) @(negedge clk);
                got[0] = txd;
                for (int i = 1; i < n; i++) begin
                    repeat (16 * (P + 1)) @(negedge clk);
                    got[i] = txd;
                end
                if (expq.size() == 0) begin
                    chk("R11 unexpected frame", {20'd0, got}, 32'hFFF);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(t, {20'd0, got}, {20'd0, e[11:0]});
                    pend--;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 txd idle", txd, 1);
        chk("R11 irq", irq, 0);
        chk("R11 rx_full", rx_full, 0);
        chk("R9 tx_empty reset", tx_empty, 1);
        chk("R9 tx_done reset", tx_done, 0);

        // R10: global gate and masks
        mask_cur = 5'b00010;
        cfg(2'd0, 1'b0);
        @(negedge clk);
        chk("R10 gated off", irq, 0);
        gint_en = 1'b1;
        @(negedge clk);
        chk("R10 txe masked in", irq, 1);
        mask_cur = 5'b10000;
        cfg(2'd0, 1'b0);
        chk("R10 rxf only", irq, 0);

        // R11: transmit disabled holds data
        tx_send(8'hA5, "R1 8N1 frame");
        repeat (40) @(negedge clk);
        chk("R11 txd held", txd, 1);
        chk("R9 tx_empty after write", tx_empty, 0);
        wr(2'd1, 8'h01);
        @(negedge clk);
        chk("R9 tx_empty after load", tx_empty, 1);
        tx_wait();
        chk("R9 tx_done", tx_done, 1);

        cfg(2'd1, 1'b0);
        tx_send(8'h3C, "R1 8N2 frame");
        chk("R9 tx_done cleared", tx_done, 0);
        tx_wait();
        cfg(2'd2, 1'b0);
        tx_send(8'h07, "R2 odd parity");
        tx_wait();
        cfg(2'd2, 1'b1);
        tx_send(8'h07, "R2 even parity");
        tx_wait();
        cfg(2'd3, 1'b1);
        tx_send(8'h55, "R3 ninth bit 1");
        tx_wait();
        cfg(2'd3, 1'b0);
        tx_send(8'hAA, "R3 ninth bit 0");
        tx_wait();

        // R4: prescaler
        cfg(2'd0, 1'b0);
        P = 3;
        wr(2'd2, 8'd3);
        tx_send(8'h96, "R4 prescaler 3");
        tx_wait();
        P = 257;
        wr(2'd1, 8'h13);
        wr(2'd2, 8'd1);
        tx_send(8'h4B, "R4 prescaler 0x101");
        tx_wait();
        P = 0;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'd0);
        repeat (4) @(negedge clk);

        // R5: reception
        rx_frame(frame_of(9'h0A5, 2'd0, 1'b0));
        chk("R5 rx_full", rx_full, 1);
        chk("R5 rx_data 8N1", rx_data, 9'h0A5);
        chk("R10 rxf irq", irq, 1);
        rd();
        chk("R5 read clears", rx_full, 0);
        chk("R10 irq drops", irq, 0);
        cfg(2'd3, 1'b0);
        rx_frame(frame_of(9'h1C3, 2'd3, 1'b0));
        chk("R5 rx_data 9 bit", rx_data, 9'h1C3);
        rd();

        // R8: parity and framing
        cfg(2'd2, 1'b1);
        rx_frame(frame_of(9'h007, 2'd2, 1'b1));
        chk("R8 good parity", rx_perr, 0);
        chk("R5 rx_data 8P1", rx_data, 9'h007);
        rd();
        rx_frame(frame_of(9'h007, 2'd2, 1'b1) ^ 16'h0200);
        chk("R8 bad parity", rx_perr, 1);
        rd();
        cfg(2'd0, 1'b0);
        rx_frame(frame_of(9'h05A, 2'd0, 1'b0) & ~16'h0200);
        chk("R8 stop low", rx_ferr, 1);
        rd();
        chk("R5 flags cleared", rx_ferr, 0);
        cfg(2'd1, 1'b0);
        rx_frame(frame_of(9'h05A, 2'd1, 1'b0) & ~16'h0400);
        chk("R8 second stop low", rx_ferr, 1);
        rd();

        // R6: overrun
        cfg(2'd0, 1'b0);
        rx_frame(frame_of(9'h011, 2'd0, 1'b0));
        rx_frame(frame_of(9'h022, 2'd0, 1'b0));
        chk("R6 overrun flag", rx_ovr, 1);
        chk("R6 old data kept", rx_data, 9'h011);
        rd();

        // R7: break
        rxd = 1'b0;
        repeat (12 * 16) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 break flag", rx_brk, 1);
        chk("R7 nothing stored", rx_full, 0);
        rd();

        // R11: receive disabled
        wr(2'd1, 8'h01);
        rx_frame(frame_of(9'h033, 2'd0, 1'b0));
        chk("R11 rx ignored", rx_full, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule